// File: doc/BRIEF.md
# Three-Wire SPI Slave with Software Framing

This block is an SPI slave that talks to a master using only the serial clock, the master-out line and the master-in line. It has no chip-select input. A frame begins when software pulses an arm strobe and ends when an internal counter has seen the programmed number of bits. While armed, the slave treats itself as selected. It samples the master-out line on every leading clock edge and moves the master-in line on every trailing edge. The first transmit bit is already on the line before the first edge.

The serial clock and master-out inputs come from another clock domain. A two-flop stage brings them into the system clock domain, and edges are found there. On the last counted bit the block does three things: it drops busy, latches the received bits right-aligned into a holding register, and raises a sticky completion flag. Software clears that flag by writing a one.

Top module: `spi3w_slave`

## Requirements
- R1: After reset, busy_o, flag_o, rx_data_o and miso_o are all 0.
- R2: While the slave is not armed, clock edges and master-out data have no effect. No bit is counted, flag_o stays 0 and rx_data_o keeps its value.
- R3: A pulse on go_i while idle sets busy_o on the next clock. While busy_o is 0, miso_o is 0.
- R4: The transmit word and bit length are captured at arming. miso_o presents the low N bits of tx_word_i MSB first, so bit N-1 comes first and is valid before the first leading edge. The line moves to the next bit after each trailing edge.
- R5: With cpol_i=0 the clock idles low, the rising edge leads and the falling edge trails. With cpol_i=1 the clock idles high, the falling edge leads and the rising edge trails. mosi_i is sampled on the leading edge.
- R6: After exactly N leading edges, busy_o falls and flag_o rises. rx_data_o then holds the N received bits right-aligned, with the first bit received as the MSB, and its upper bits are 0.
- R7: A bit_len_i code of 1 to 31 gives that many bits. A code of 0 gives 32 bits.
- R8: flag_o stays set until a cycle with clr_i=1. If completion and clr_i fall in the same cycle, the flag is set.
- R9: A go_i pulse while busy_o=1 is ignored. The transfer in progress keeps its count, its data and its transmit word.
- R10: rx_data_o changes only at completion. Clock activity after completion does not alter it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | Serial clock from the master (asynchronous) |
| mosi_i | input | 1 | Master-out serial data (asynchronous) |
| go_i | input | 1 | Arm strobe, one system clock wide |
| clr_i | input | 1 | Write-one-to-clear of the completion flag |
| bit_len_i | input | 5 | Bit count code, with 0 meaning 32 |
| tx_word_i | input | 32 | Word to transmit, low bits used |
| cpol_i | input | 1 | Clock polarity (idle level) |
| miso_o | output | 1 | Master-in serial data |
| rx_data_o | output | 32 | Last received word, right-aligned |
| flag_o | output | 1 | Sticky unit-transfer completion flag |
| busy_o | output | 1 | High while armed and counting |

## Verification
The assertions assume three things about the inputs. The serial clock's half period spans several system clocks, so each synchronised edge is seen once. cpol_i is constant while busy. The master drives the idle level given by cpol_i before arming. The stimulus meets these conditions by holding each clock phase for eight system clocks. It also sets the polarity and idle level a few cycles before each arm strobe and changes master-out data only on the trailing phase. The sweep covers every length code under both polarities. It adds a clock run before arming, a stray arm strobe mid-frame and a clear that lands in the completion cycle.

// File: rtl/spi3w_pkg.sv
package spi3w_pkg;
  typedef struct packed {
    logic lead;
    logic trail;
  } sclk_edge_t;
endpackage

// File: rtl/spi3w_sync.sv
module spi3w_sync #(
  parameter int unsigned W      = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] chain_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q[s] <= '0;
      else if (s == 0) chain_q[s] <= d_i;
      else chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/spi3w_edge.sv
module spi3w_edge
  import spi3w_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sclk_s_i,
  input  logic       cpol_i,
  output sclk_edge_t edge_o
);
  logic prev_q;
  logic rise, fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sclk_s_i;
  end

  assign rise = sclk_s_i & ~prev_q;
  assign fall = ~sclk_s_i & prev_q;

  // leading edge leaves the idle level
  always_comb begin
    edge_o.lead  = cpol_i ? fall : rise;
    edge_o.trail = cpol_i ? rise : fall;
  end
endmodule

// File: rtl/spi3w_core.sv
module spi3w_core
  import spi3w_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned LEN_W = $clog2(DATA_W),
  localparam int unsigned CNT_W = LEN_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  sclk_edge_t        edge_i,
  input  logic              mosi_s_i,
  input  logic              go_i,
  input  logic              clr_i,
  input  logic [LEN_W-1:0]  bit_len_i,
  input  logic [DATA_W-1:0] tx_word_i,
  output logic              miso_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              flag_o,
  output logic              busy_o
);
  localparam logic [CNT_W-1:0] FULL_LEN = CNT_W'(DATA_W);

  logic [CNT_W-1:0]  len_q, cnt_q, len_d, cnt_nxt, pad;
  logic [DATA_W-1:0] tx_sh_q, rx_sh_q, rx_nxt, rx_data_q;
  logic              busy_q, flag_q, arm, done;

  assign len_d   = (bit_len_i == '0) ? FULL_LEN : {1'b0, bit_len_i};
  assign pad     = FULL_LEN - len_d;
  assign arm     = go_i & ~busy_q;
  assign cnt_nxt = cnt_q + 1'b1;
  assign rx_nxt  = {rx_sh_q[DATA_W-2:0], mosi_s_i};
  assign done    = busy_q & edge_i.lead & (cnt_nxt == len_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q    <= 1'b0;
      len_q     <= '0;
      cnt_q     <= '0;
      tx_sh_q   <= '0;
      rx_sh_q   <= '0;
      rx_data_q <= '0;
    end else if (arm) begin
      busy_q  <= 1'b1;
      len_q   <= len_d;
      cnt_q   <= '0;
      rx_sh_q <= '0;
      tx_sh_q <= tx_word_i << pad;  // MSB of frame to top bit
    end else if (busy_q) begin
      if (edge_i.lead) begin
        rx_sh_q <= rx_nxt;
        cnt_q   <= cnt_nxt;
        if (done) begin
          busy_q    <= 1'b0;
          rx_data_q <= rx_nxt;
        end
      end
      if (edge_i.trail) tx_sh_q <= tx_sh_q << 1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flag_q <= 1'b0;
    else if (done)  flag_q <= 1'b1;  // set beats clear
    else if (clr_i) flag_q <= 1'b0;
  end

  assign miso_o    = busy_q & tx_sh_q[DATA_W-1];
  assign rx_data_o = rx_data_q;
  assign flag_o    = flag_q;
  assign busy_o    = busy_q;
endmodule

// File: rtl/spi3w_slave.sv
module spi3w_slave
  import spi3w_pkg::*;
#(
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned LEN_W      = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              mosi_i,
  input  logic              go_i,
  input  logic              clr_i,
  input  logic [LEN_W-1:0]  bit_len_i,
  input  logic [DATA_W-1:0] tx_word_i,
  input  logic              cpol_i,
  output logic              miso_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              flag_o,
  output logic              busy_o
);
  logic [1:0] pins_s;
  sclk_edge_t sclk_edge;

  spi3w_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({sclk_i, mosi_i}),
    .q_o   (pins_s)
  );

  spi3w_edge u_edge (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sclk_s_i(pins_s[1]),
    .cpol_i  (cpol_i),
    .edge_o  (sclk_edge)
  );

  spi3w_core #(.DATA_W(DATA_W)) u_core (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .edge_i   (sclk_edge),
    .mosi_s_i (pins_s[0]),
    .go_i     (go_i),
    .clr_i    (clr_i),
    .bit_len_i(bit_len_i),
    .tx_word_i(tx_word_i),
    .miso_o   (miso_o),
    .rx_data_o(rx_data_o),
    .flag_o   (flag_o),
    .busy_o   (busy_o)
  );
endmodule

// File: rtl/spi3w_slave_chk.sv
module spi3w_slave_chk #(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              go_i,
  input logic              clr_i,
  input logic              miso_o,
  input logic [DATA_W-1:0] rx_data_o,
  input logic              flag_o,
  input logic              busy_o
);
  // R3
  arm_starts_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_i && !busy_o |=> busy_o);
  // R3
  idle_miso_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !miso_o);
  // R6
  flag_from_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_o) |-> $past(busy_o));
  // R6
  end_sets_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> flag_o);
  // R8
  flag_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_o && !clr_i |=> flag_o);
  // R10
  rx_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |=> $stable(rx_data_o));
endmodule

bind spi3w_slave spi3w_slave_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .go_i     (go_i),
  .clr_i    (clr_i),
  .miso_o   (miso_o),
  .rx_data_o(rx_data_o),
  .flag_o   (flag_o),
  .busy_o   (busy_o)
);

// File: tb/tb_spi3w_slave.sv
`timescale 1ns/1ps
module tb_spi3w_slave;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sclk_i = 1'b0, mosi_i = 1'b0, go_i = 1'b0, clr_i = 1'b0, cpol_i = 1'b0;
  logic [4:0]  bit_len_i = '0;
  logic [31:0] tx_word_i = '0;
  logic        miso_o, flag_o, busy_o;
  logic [31:0] rx_data_o;

  int total = 0, fails = 0;
  bit finished = 0;

  always #4 clk_i = ~clk_i;

  spi3w_slave dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .sclk_i(sclk_i), .mosi_i(mosi_i),
    .go_i(go_i), .clr_i(clr_i), .bit_len_i(bit_len_i), .tx_word_i(tx_word_i),
    .cpol_i(cpol_i), .miso_o(miso_o), .rx_data_o(rx_data_o), .flag_o(flag_o),
    .busy_o(busy_o)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic xfer(input logic [4:0] code, input logic [31:0] tx, input logic [31:0] rxw,
                      input bit cp, input bit go_mid, input bit clr_race);
    int n;
    int miso_err;
    logic [31:0] mask, exp_rx;
    n = (code == 0) ? 32 : int'(code);
    mask = (n == 32) ? 32'hFFFF_FFFF : ((32'h1 << n) - 1);
    exp_rx = rxw & mask;
    miso_err = 0;
    cpol_i = cp; sclk_i = cp; mosi_i = 1'b0;
    wait_n(4);
    clr_i = 1'b1; wait_n(1); clr_i = 1'b0;
    bit_len_i = code; tx_word_i = tx; go_i = 1'b1;
    wait_n(1);
    go_i = 1'b0; tx_word_i = ~tx; bit_len_i = code + 5'd3;
    wait_n(3);
    chk(busy_o === 1'b1, "R3 busy after arm", 32'(busy_o), 32'd1);
    for (int i = 0; i < n; i++) begin
      mosi_i = rxw[n-1-i];
      wait_n(8);
      if (miso_o !== tx[n-1-i]) miso_err++;
      if (i == n-1 && clr_race) begin
        clr_i = 1'b1;
        sclk_i = ~sclk_i;
        repeat (3) @(posedge clk_i);
        @(negedge clk_i);
        clr_i = 1'b0;
        wait_n(7);
      end else begin
        sclk_i = ~sclk_i;
        wait_n(8);
      end
      if (go_mid && i == n/2) begin
        go_i = 1'b1; tx_word_i = 32'h0; wait_n(1); go_i = 1'b0;
      end
      sclk_i = ~sclk_i;
    end
    wait_n(8);
    chk(busy_o === 1'b0, go_mid ? "R9 busy ends at original count" : "R6 busy falls", 32'(busy_o), 32'd0);
    chk(flag_o === 1'b1, clr_race ? "R8 set wins over clear" : "R6 flag set", 32'(flag_o), 32'd1);
    chk(rx_data_o === exp_rx, (code == 0) ? "R7 32-bit receive" : (cp ? "R5 cpol1 receive" : "R6 receive"),
        rx_data_o, exp_rx);
    chk(miso_err == 0, go_mid ? "R9 miso unchanged by stray arm" : "R4 miso bit order", 32'(miso_err), 32'd0);
    chk(miso_o === 1'b0, "R3 miso idle low", 32'(miso_o), 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!finished) begin
      total++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [31:0] tx, rxw, held;
    wait_n(3);
    chk(busy_o === 1'b0, "R1 busy reset", 32'(busy_o), 32'd0);
    chk(flag_o === 1'b0, "R1 flag reset", 32'(flag_o), 32'd0);
    chk(rx_data_o === 32'h0, "R1 rx reset", rx_data_o, 32'h0);
    chk(miso_o === 1'b0, "R1 miso reset", 32'(miso_o), 32'd0);
    rst_ni = 1'b1;
    wait_n(2);

    // R2: clock activity before arming
    mosi_i = 1'b1;
    for (int k = 0; k < 40; k++) begin
      sclk_i = ~sclk_i; wait_n(8);
    end
    chk(flag_o === 1'b0, "R2 flag idle", 32'(flag_o), 32'd0);
    chk(busy_o === 1'b0, "R2 busy idle", 32'(busy_o), 32'd0);
    chk(rx_data_o === 32'h0, "R2 rx idle", rx_data_o, 32'h0);
    xfer(5'd3, 32'h5, 32'h2, 1'b0, 1'b0, 1'b0);

    // sweep all length codes, both polarities
    for (int cp = 0; cp < 2; cp++) begin
      for (int c = 0; c < 32; c++) begin
        tx  = 32'hA5C3_0F96 ^ (32'(c) * 32'h0101_0101) ^ {32{cp[0]}};
        rxw = {tx[12:0], tx[31:13]} ^ 32'h3C5A_96E1;
        xfer(5'(c), tx, rxw, cp[0], (c == 20), (c == 7));
      end
    end

    // R8 flag held with no clear
    wait_n(40);
    chk(flag_o === 1'b1, "R8 flag sticky", 32'(flag_o), 32'd1);
    clr_i = 1'b1; wait_n(1); clr_i = 1'b0; wait_n(1);
    chk(flag_o === 1'b0, "R8 flag cleared", 32'(flag_o), 32'd0);

    // R10 idle clocking after completion
    held = rx_data_o;
    for (int k = 0; k < 12; k++) begin
      mosi_i = k[0]; sclk_i = ~sclk_i; wait_n(8);
    end
    chk(rx_data_o === held, "R10 rx held", rx_data_o, held);
    chk(flag_o === 1'b0, "R2 no flag from idle clocks", 32'(flag_o), 32'd0);

    finished = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule